// File: doc/BRIEF.md
# Serial Output Frame Formatter

This block turns 16-bit conversion results into a framed serial stream for a DSP serial port. A strobe with a result word starts the stream. From then on the block sends one frame after another. Each frame carries the most recently captured word, MSB first. The block also generates the serial clock, a frame-sync output and a data-enable flag. A receiving port or a second formatter can use that flag to share one data line.

Static controls set the behaviour:
- frame length: a 32-bit frame that ends in 16 zero bits, or a 16-bit frame with no padding;
- serial clock rate: the master clock rate or half of it;
- the serial clock edge on which data is valid;
- frame-sync form: a one-bit pulse, or a low envelope that covers the data bits;
- a slot level that the output-enable level must match before the data line is driven.

At the default settings (32-bit frames at full rate, or 16-bit frames at half rate) a frame spans 32 master clocks. An external sync input restarts the framing on the next edge, so several formatters on a common master clock stay aligned. The high-impedance state of the data pin is modelled as the separate `sdata_en` output.

Top module: `ser_frame_tx`

## Requirements
- R1: After synchronous reset, and until the first word strobe or sync input: `sdata_en`=0, `sdata`=0, `sclk`=0, and `fs_out` is inactive (0 when `fs_env`=0, 1 when `fs_env`=1).
- R2: A frame starts on the master clock edge that samples `word_stb`=1 while the block is idle. Frame bit b (b from 0) shows word bit 15-b on `sdata`, so the MSB comes first.
- R3: With `pad_mode`=1, a frame is 32 bit periods long. Bits 16 to 31 are 0, and frames repeat back to back.
- R4: With `pad_mode`=0, a frame is 16 bit periods long. Frames follow each other with no gap and no padding.
- R5: With `half_rate`=0, each bit lasts one master clock. With `half_rate`=1, each bit lasts two master clocks, and `sclk` (for `clk_fmt`=0) is 1 in the first clock of the bit and 0 in the second.
- R6: With `clk_fmt`=0, `sclk` rises where data changes, so data is valid on the falling edge. At full rate `sclk` equals the master clock. With `clk_fmt`=1, `sclk` is inverted, so data is valid on the rising edge.
- R7: With `fs_env`=0, `fs_out` is 1 during frame bit 0 only and 0 otherwise.
- R8: With `fs_env`=1, `fs_out` is 0 during frame bits 0 to 15 and 1 during the padding bits.
- R9: While a stream is running, `sdata_en` is 1 exactly when `oe_lvl` equals `slot_sel`.
- R10: A word strobed during a frame does not alter that frame. The next frame carries the latest strobed word.
- R11: `fsync_in`=1 restarts the framing at bit 0, with the clock phase reset, on the next master clock edge. The restarted frame carries the latest strobed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| word_stb | input | 1 | New result strobe |
| word_in | input | 16 | Result word |
| pad_mode | input | 1 | 1: 32-bit padded frames, 0: 16-bit frames |
| half_rate | input | 1 | 1: serial clock at half master rate |
| clk_fmt | input | 1 | Valid serial clock edge select |
| fs_env | input | 1 | 1: envelope frame sync, 0: pulse |
| slot_sel | input | 1 | Active level of `oe_lvl` |
| oe_lvl | input | 1 | Output enable level |
| fsync_in | input | 1 | Framing restart |
| sclk | output | 1 | Serial clock |
| fs_out | output | 1 | Frame sync |
| sdata | output | 1 | Serial data |
| sdata_en | output | 1 | Data drive enable |

## Verification
The first frame's bit 0 appears just after the edge that samples the strobe, or just after the edge that samples `fsync_in`. Every later bit is due exactly one bit period (one or two master clocks) after the previous one. A mid-frame word first shows up at the next frame boundary. The bench counts master clocks from the load edge. For every cycle it computes the bit index and frame number, and from them the expected data, frame sync and enable. It samples one nanosecond after each rising edge, and samples `sclk` again after each falling edge, so it sees both levels of the full-rate clock.

// File: rtl/sft_pkg.sv
package sft_pkg;

    localparam int WORD_W = 16;

    typedef struct packed {
        logic pad;    // padded long frame
        logic half;   // half-rate serial clock
        logic cfmt;   // inverted serial clock
        logic env;    // envelope frame sync
    } sft_cfg_t;

    function automatic int unsigned frame_bits(input logic pad, input int unsigned w);
        return pad ? 2 * w : w;
    endfunction

endpackage

// File: rtl/sft_clkdiv.sv
module sft_clkdiv (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic active,
    input  sft_pkg::sft_cfg_t cfg,
    output logic tick,
    output logic ph,
    output logic sclk
);
    logic base;

    always_ff @(posedge clk) begin
        if (rst)          ph <= 1'b0;
        else if (restart) ph <= 1'b0;
        else if (active)  ph <= ~ph;
    end

    // a bit ends on every clock at full rate, on the second phase at half rate
    assign tick = active & (cfg.half ? ph : 1'b1);
    assign base = cfg.half ? ~ph : clk;
    assign sclk = active & (base ^ cfg.cfmt);
endmodule

// File: rtl/sft_seq.sv
module sft_seq #(
    parameter int W     = 16,
    parameter int CNT_W = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic tick,
    input  logic active,
    input  sft_pkg::sft_cfg_t cfg,
    output logic frame_end,
    output logic fs_out
);
    logic [CNT_W-1:0] bit_idx;
    logic [CNT_W:0]   last_idx;
    logic             in_data;

    assign last_idx  = (CNT_W+1)'(sft_pkg::frame_bits(cfg.pad, W) - 1);
    assign frame_end = tick & ({1'b0, bit_idx} == last_idx);
    assign in_data   = ({1'b0, bit_idx} < (CNT_W+1)'(W));

    always_ff @(posedge clk) begin
        if (rst)            bit_idx <= '0;
        else if (restart)   bit_idx <= '0;
        else if (frame_end) bit_idx <= '0;
        else if (tick)      bit_idx <= bit_idx + 1'b1;
    end

    always_comb begin
        if (!active)      fs_out = cfg.env;
        else if (cfg.env) fs_out = ~in_data;
        else              fs_out = (bit_idx == '0);
    end
endmodule

// File: rtl/sft_shreg.sv
module sft_shreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         tick,
    input  logic         word_stb,
    input  logic [W-1:0] word_in,
    output logic         msb
);
    logic [W-1:0] hold_q;
    logic [W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            sh_q   <= '0;
        end else begin
            if (word_stb) hold_q <= word_in;
            if (load)      sh_q <= word_stb ? word_in : hold_q;
            else if (tick) sh_q <= {sh_q[W-2:0], 1'b0};
        end
    end

    assign msb = sh_q[W-1];
endmodule

// File: rtl/ser_frame_tx.sv
module ser_frame_tx #(
    parameter int W = sft_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         word_stb,
    input  logic [W-1:0] word_in,
    input  logic         pad_mode,
    input  logic         half_rate,
    input  logic         clk_fmt,
    input  logic         fs_env,
    input  logic         slot_sel,
    input  logic         oe_lvl,
    input  logic         fsync_in,
    output logic         sclk,
    output logic         fs_out,
    output logic         sdata,
    output logic         sdata_en
);
    localparam int CNT_W = $clog2(2 * W);

    sft_pkg::sft_cfg_t cfg;
    logic active_q, restart, tick, ph, frame_end, msb;

    assign cfg     = '{pad: pad_mode, half: half_rate, cfmt: clk_fmt, env: fs_env};
    assign restart = fsync_in | (word_stb & ~active_q);

    always_ff @(posedge clk) begin
        if (rst)          active_q <= 1'b0;
        else if (restart) active_q <= 1'b1;
    end

    sft_clkdiv u_div (
        .clk(clk), .rst(rst), .restart(restart), .active(active_q),
        .cfg(cfg), .tick(tick), .ph(ph), .sclk(sclk)
    );

    sft_seq #(.W(W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst(rst), .restart(restart), .tick(tick),
        .active(active_q), .cfg(cfg), .frame_end(frame_end), .fs_out(fs_out)
    );

    sft_shreg #(.W(W)) u_sh (
        .clk(clk), .rst(rst), .load(restart | frame_end), .tick(tick),
        .word_stb(word_stb), .word_in(word_in), .msb(msb)
    );

    assign sdata    = active_q & msb;
    assign sdata_en = active_q & (oe_lvl == slot_sel);
endmodule

// File: rtl/sft_chk.sv
module sft_chk (
    input logic clk,
    input logic rst,
    input logic pad_mode,
    input logic half_rate,
    input logic fs_env,
    input logic fsync_in,
    input logic sclk,
    input logic fs_out,
    input logic sdata,
    input logic sdata_en,
    input logic active,
    input logic ph
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!sdata_en && !sdata && !sclk));

    // R3
    pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (active && pad_mode && fs_env && fs_out) |-> !sdata);

    // R5
    half_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (active && half_rate && !ph && !fsync_in) |=> $stable(sdata));

    // R7
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !fs_env && !half_rate && fs_out && !fsync_in) |=> !fs_out);

    // R11
    sync_start_chk: assert property (@(posedge clk) disable iff (rst)
        (fsync_in && !fs_env) |=> fs_out);
endmodule

bind ser_frame_tx sft_chk u_chk (
    .clk(clk), .rst(rst), .pad_mode(pad_mode), .half_rate(half_rate),
    .fs_env(fs_env), .fsync_in(fsync_in), .sclk(sclk), .fs_out(fs_out),
    .sdata(sdata), .sdata_en(sdata_en), .active(active_q), .ph(ph)
);

// File: tb/sim_ser_frame_tx.sv
module sim_ser_frame_tx;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic word_stb = 1'b0;
    logic [15:0] word_in = '0;
    logic pad_mode = 1'b0, half_rate = 1'b0, clk_fmt = 1'b0, fs_env = 1'b0;
    logic slot_sel = 1'b0, oe_lvl = 1'b0, fsync_in = 1'b0;
    logic sclk, fs_out, sdata, sdata_en;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [15:0] words [0:3];

    always #2 clk = ~clk;

    ser_frame_tx u0 (
        .clk(clk), .rst(rst), .word_stb(word_stb), .word_in(word_in),
        .pad_mode(pad_mode), .half_rate(half_rate), .clk_fmt(clk_fmt),
        .fs_env(fs_env), .slot_sel(slot_sel), .oe_lvl(oe_lvl),
        .fsync_in(fsync_in), .sclk(sclk), .fs_out(fs_out),
        .sdata(sdata), .sdata_en(sdata_en)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
        end
    endtask

    function automatic logic exp_data(input logic [15:0] w, input int b);
        return (b < 16) ? w[15-b] : 1'b0;
    endfunction

    function automatic logic exp_fs(input logic env, input int b);
        return env ? (b >= 16) : (b == 0);
    endfunction

    task automatic run_cfg(input logic pad, input logic half, input logic cf,
                           input logic env, input logic match);
        int per, len, total, k, seg, b_all, f, b;
        logic [15:0] w;
        @(negedge clk);
        rst = 1'b1; word_stb = 1'b0; fsync_in = 1'b0;
        pad_mode = pad; half_rate = half; clk_fmt = cf; fs_env = env;
        slot_sel = 1'($urandom % 2);
        oe_lvl = match ? slot_sel : ~slot_sel;
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        check("R1 en", sdata_en, 1'b0);
        check("R1 data", sdata, 1'b0);
        check("R1 sclk", sclk, 1'b0);
        check("R1 fs", fs_out, env);
        @(negedge clk);
        words[0] = 16'($urandom);
        word_stb = 1'b1; word_in = words[0];
        per = half ? 2 : 1;
        len = pad ? 32 : 16;
        total = 3 * len * per;
        k = 0; seg = 0;
        while (seg == 0 ? 1 : (k < len * per)) begin
            @(posedge clk); #1;
            b_all = k / per;
            f = b_all / len;
            b = b_all % len;
            w = (seg == 1) ? words[2] : words[f];
            if (seg == 1)      check("R11 data", sdata, exp_data(w, b));
            else if (b >= 16)  check("R3 pad", sdata, 1'b0);
            else if (f == 0)   check("R2 data", sdata, exp_data(w, b));
            else if (pad)      check("R10 data", sdata, exp_data(w, b));
            else               check("R4 data", sdata, exp_data(w, b));
            check(env ? "R8 fs" : "R7 fs", fs_out, exp_fs(env, b));
            check("R9 en", sdata_en, match);
            check(half ? "R5 sclk" : "R6 sclk", sclk, cf ^ (half ? (k % 2 == 0) : 1'b1));
            @(negedge clk); #1;
            check(half ? "R5 sclk lo" : "R6 sclk lo", sclk, cf ^ (half ? (k % 2 == 0) : 1'b0));
            word_stb = 1'b0; fsync_in = 1'b0;
            if (seg == 0 && f < 2 && (k % (len * per)) == 5 * per) begin
                words[f+1] = 16'($urandom);
                word_stb = 1'b1; word_in = words[f+1];
            end
            if (seg == 0 && k == 2 * len * per + 7) begin
                fsync_in = 1'b1; seg = 1; k = 0;
            end else begin
                k++;
            end
            if (seg == 0 && k > total) begin
                errors++;
                $display("FAIL R11 sync never issued actual=%0d expected=%0d", k, total);
                seg = 2;
            end
            if (seg == 2) break;
        end
    endtask

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(posedge clk);
        // directed corners first, then the full grid with random words and slots
        run_cfg(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        run_cfg(1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        run_cfg(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        for (int c = 0; c < 32; c++)
            run_cfg(c[0], c[1], c[2], c[3], c[4]);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule